// File: doc/BRIEF.md
# Flash User-Mode Dummy Byte Inserter

This block sits beside the byte path of a serial flash controller while software drives a transfer by hand. It watches the writes that software issues once a chip select becomes active. The low byte of the first write is the command opcode. The block looks that opcode up to find how many wait bytes the command needs before data.

It then counts the bytes that follow. When the command and address bytes have gone out, the next write is swallowed. In its place the block issues a burst of wait bytes, each one carrying a configurable fill value. Software therefore never has to produce the wait phase itself.

Each write gets a pass or suppress decision in the same cycle it is accepted. The burst comes out as a byte-per-cycle request stream. While a burst is running, the write port is stalled.

Top module: `dummy_inserter`

## Requirements
- R1: After reset, no burst is pending, `wr_ready` is 1, and writes pass without snooping until the first `cs_assert`, so even a fast-read opcode written before any `cs_assert` produces no wait bytes.
- R2: While snooping is off, every accepted write has `wr_pass`=1 and no wait bytes are emitted.
- R3: After a `cs_assert`, `wr_data[7:0]` of the first accepted write is taken as the opcode.
- R4: The opcode sets a unit count: 4 for 0xEB and 0xEC; 2 for 0xBB, 0xBC and 0x0C; 1 for 0x0B, 0x3B, 0x3C, 0x6B and 0x6C; 0 for every other value. The burst length is the unit count times 8 bytes.
- R5: An opcode with a unit count of 0 turns snooping off, and that write and all later ones pass.
- R6: While snooping, each passed write advances the byte position by `wr_size` (1 to 4), counting the opcode write.
- R7: The first write accepted once the position is at least the address width plus 1 (3 bytes when `addr4`=0, 4 bytes when `addr4`=1) is suppressed (`wr_pass`=0). From the next cycle, `dummy_valid` is high for exactly the burst length, one byte per cycle. Every burst byte carries the `dummy_fill` value sampled with the suppressed write.
- R8: While a burst runs, `wr_ready` is 0 and `wr_pass` is 0. `wr_ready` returns to 1 in the cycle after the last burst byte.
- R9: After a burst, snooping is off, so later writes pass until the next `cs_assert`.
- R10: A `cs_release` turns snooping off. Its effect is visible in the next cycle, where `dummy_valid` is 0 and any running burst has been cancelled.
- R11: A write accepted in the same cycle as a `cs_assert` passes and is not taken as the opcode. The first write after it is the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_assert | input | 1 | One-cycle pulse: chip select became active. It starts snooping and cancels any burst. |
| cs_release | input | 1 | One-cycle pulse: chip select became inactive. It has priority over `cs_assert`. |
| wr_valid | input | 1 | A user-mode write is offered |
| wr_ready | output | 1 | Write can be accepted (low during a burst) |
| wr_data | input | 32 | Write bytes, with the first byte in bits [7:0] |
| wr_size | input | 3 | Number of bytes in the write, from 1 to 4 |
| addr4 | input | 1 | 1 selects 4-byte addresses, 0 selects 3-byte addresses |
| dummy_fill | input | 8 | Value carried by each wait byte |
| wr_pass | output | 1 | The accepted write is forwarded to the shifter |
| dummy_valid | output | 1 | A wait byte is requested this cycle |
| dummy_data | output | 8 | Value of the requested wait byte |

## Verification
The assertions guard the local invariants on every cycle. A forwarded write always coincides with an accepted one. A firing trigger always returns the position to the off code. A release always leaves the next cycle with no burst. While a burst runs, its fill value holds still and its counter steps down by exactly one.

Only the bench scenarios can show the end-to-end outcomes. These are the opcode-to-length mapping over all 256 opcodes and both address widths, and the exact write on which suppression happens when address bytes arrive in different write sizes. They also cover the stall length seen by a waiting write and the handling of a write that coincides with a chip-select event.

// File: rtl/dummy_ins_pkg.sv
package dummy_ins_pkg;
    localparam int unsigned POS_W     = 8;
    localparam logic [POS_W-1:0] POS_OFF   = 8'hFF;
    localparam logic [POS_W-1:0] POS_START = 8'h00;

    // position at which the address phase is complete
    function automatic logic [POS_W-1:0] addr_done_pos(input logic wide);
        return wide ? POS_W'(5) : POS_W'(4);
    endfunction
endpackage

// File: rtl/opcode_wait_lut.sv
module opcode_wait_lut #(
    parameter int unsigned UNIT_W = 3
) (
    input  logic [7:0]        opcode,
    output logic [UNIT_W-1:0] units
);
    always_comb begin
        case (opcode)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = UNIT_W'(1);
            8'hBB, 8'h0C, 8'hBC:               units = UNIT_W'(2);
            8'hEB, 8'hEC:                      units = UNIT_W'(4);
            default:                           units = '0;
        endcase
    end
endmodule

// File: rtl/wait_burst_gen.sv
module wait_burst_gen #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic [7:0]       fill_in,
    input  logic             abort,
    output logic             busy,
    output logic [7:0]       fill_out
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [7:0]       fill;
    } burst_t;

    burst_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (abort) begin
            nxt_d.count = '0;
        end else if (load) begin
            nxt_d.count = load_count;
            nxt_d.fill  = fill_in;
        end else if (cur_q.count != '0) begin
            nxt_d.count = cur_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy     = (cur_q.count != '0);
    assign fill_out = cur_q.fill;

    assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !abort) |=> $stable(fill_out));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !abort) |=> (cur_q.count == $past(cur_q.count) - CNT_W'(1)));
endmodule

// File: rtl/dummy_inserter.sv
module dummy_inserter
    import dummy_ins_pkg::*;
#(
    parameter int unsigned DATA_BYTES     = 4,
    parameter int unsigned MAX_UNITS      = 4,
    parameter int unsigned BYTES_PER_UNIT = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cs_assert,
    input  logic                            cs_release,
    input  logic                            wr_valid,
    output logic                            wr_ready,
    input  logic [8*DATA_BYTES-1:0]         wr_data,
    input  logic [$clog2(DATA_BYTES+1)-1:0] wr_size,
    input  logic                            addr4,
    input  logic [7:0]                      dummy_fill,
    output logic                            wr_pass,
    output logic                            dummy_valid,
    output logic [7:0]                      dummy_data
);
    localparam int unsigned UNIT_W  = $clog2(MAX_UNITS + 1);
    localparam int unsigned PEND_W  = $clog2(MAX_UNITS * BYTES_PER_UNIT + 1);
    localparam int unsigned PEND_MX = MAX_UNITS * BYTES_PER_UNIT;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [PEND_W-1:0] pend;
    } track_t;

    track_t trk_q, trk_d;
    logic [UNIT_W-1:0] units;
    logic busy, accept, snooping, at_start, past_addr, fire, pass_d;

    opcode_wait_lut #(.UNIT_W(UNIT_W)) u_lut (
        .opcode (wr_data[7:0]),
        .units  (units)
    );

    assign accept    = wr_valid && !busy;
    assign snooping  = (trk_q.pos != POS_OFF);
    assign at_start  = (trk_q.pos == POS_START);
    assign past_addr = snooping && !at_start && (trk_q.pos >= addr_done_pos(addr4));

    always_comb begin
        trk_d  = trk_q;
        fire   = 1'b0;
        pass_d = accept;
        if (cs_release) begin
            trk_d.pos  = POS_OFF;
            trk_d.pend = '0;
        end else if (cs_assert) begin
            trk_d.pos  = POS_START;
            trk_d.pend = '0;
        end else if (accept && snooping) begin
            if (at_start) begin
                if (units == '0) begin
                    trk_d.pos = POS_OFF;
                end else begin
                    trk_d.pend = PEND_W'(units) * PEND_W'(BYTES_PER_UNIT);
                    trk_d.pos  = trk_q.pos + POS_W'(wr_size);
                end
            end else if (past_addr) begin
                fire       = 1'b1;
                pass_d     = 1'b0;
                trk_d.pos  = POS_OFF;
                trk_d.pend = '0;
            end else begin
                trk_d.pos = trk_q.pos + POS_W'(wr_size);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.pos  <= POS_OFF;
            trk_q.pend <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    wait_burst_gen #(.CNT_W(PEND_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fire),
        .load_count (trk_q.pend),
        .fill_in    (dummy_fill),
        .abort      (cs_release || cs_assert),
        .busy       (busy),
        .fill_out   (dummy_data)
    );

    assign wr_ready    = !busy;
    assign wr_pass     = pass_d;
    assign dummy_valid = busy;

    assert_pass_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pass |-> (wr_valid && wr_ready));

    assert_fire_ends_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (trk_q.pos == POS_OFF));

    assert_release_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_release |=> (trk_q.pos == POS_OFF && !dummy_valid));

    assert_pend_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.pend <= PEND_W'(PEND_MX));
endmodule

// File: tb/tb_dummy_inserter.sv
module tb_dummy_inserter;
    logic clk = 0;
    logic rst_n = 0;
    logic cs_assert = 0, cs_release = 0, wr_valid = 0, addr4 = 0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_size = 3'd1;
    logic [7:0]  dummy_fill = '0;
    logic wr_ready, wr_pass, dummy_valid;
    logic [7:0] dummy_data;
    int total = 0, bad = 0, cycles = 0;

    always #2.5 clk = ~clk;

    dummy_inserter dut (
        .clk(clk), .rst_n(rst_n), .cs_assert(cs_assert), .cs_release(cs_release),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_size(wr_size),
        .addr4(addr4), .dummy_fill(dummy_fill), .wr_pass(wr_pass),
        .dummy_valid(dummy_valid), .dummy_data(dummy_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // unit counts taken from R4
    function automatic int units_of(input logic [7:0] op);
        case (op)
            8'hEB, 8'hEC:                      return 4;
            8'hBB, 8'hBC, 8'h0C:               return 2;
            8'h0B, 8'h3B, 8'h3C, 8'h6B, 8'h6C: return 1;
            default:                           return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cs_pulse(input bit rel);
        @(negedge clk);
        if (rel) cs_release = 1; else cs_assert = 1;
        @(posedge clk);
        #1;
        cs_release = 0;
        cs_assert = 0;
    endtask

    task automatic wr(input logic [31:0] d, input int sz, input bit exp_pass, input string req);
        @(negedge clk);
        wr_valid = 1;
        wr_data = d;
        wr_size = 3'(sz);
        #1;
        chk(wr_ready == 1, req, int'(wr_ready), 1);
        chk(wr_pass == exp_pass, req, int'(wr_pass), int'(exp_pass));
        @(posedge clk);
        #1;
        wr_valid = 0;
    endtask

    task automatic drain(input int exp_n, input logic [7:0] fill, input string req);
        int n = 0;
        int wrong = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!dummy_valid) break;
            if (dummy_data != fill) wrong++;
            n++;
        end
        chk(n == exp_n, req, n, exp_n);
        chk(wrong == 0, req, wrong, 0);
    endtask

    initial begin
        #12;
        rst_n = 1;
        // R1 reset state and no snooping before any chip select
        @(negedge clk);
        chk(wr_ready == 1 && dummy_valid == 0, "R1", int'(dummy_valid), 0);
        wr(32'h0B, 1, 1, "R1");
        wr(32'h00123456, 3, 1, "R2");
        wr(32'h0, 2, 1, "R2");
        drain(0, 8'h00, "R1");

        // exhaustive opcode sweep, both address widths (R3 R4 R5 R7 R9)
        for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 256; op++) begin
                int u;
                logic [7:0] f;
                u = units_of(8'(op));
                f = 8'(op) ^ 8'h5A;
                addr4 = w[0];
                dummy_fill = f;
                cs_pulse(0);
                wr(32'(op), 1, 1, "R3");
                wr(32'hA1B2C3D4, w ? 4 : 3, 1, "R6");
                wr(32'h7777, 2, u == 0, u == 0 ? "R5" : "R7");
                dummy_fill = ~f;
                drain(u * 8, f, "R4");
                wr(32'hFFFFFFFF, 4, 1, "R9");
                drain(0, ~f, "R9");
            end
        end

        // R6 opcode and address in one write, 3-byte addresses
        addr4 = 0; dummy_fill = 8'hC3;
        cs_pulse(0);
        wr(32'h1122330B, 4, 1, "R6");
        wr(32'h55, 1, 0, "R6");
        drain(8, 8'hC3, "R6");
        // R6 with 4-byte addresses: needs one more byte
        addr4 = 1; dummy_fill = 8'h3C;
        cs_pulse(0);
        wr(32'h112233BB, 4, 1, "R6");
        wr(32'h44, 1, 1, "R6");
        wr(32'h55, 1, 0, "R6");
        drain(16, 8'h3C, "R6");
        // R6 single-byte address writes
        addr4 = 0; dummy_fill = 8'h99;
        cs_pulse(0);
        wr(32'hEB, 1, 1, "R6");
        wr(32'h01, 1, 1, "R6");
        wr(32'h02, 1, 1, "R6");
        wr(32'h03, 1, 1, "R6");
        wr(32'h04, 1, 0, "R6");
        drain(32, 8'h99, "R6");

        // R8 stall: a waiting write sees ready low for the whole burst
        cs_pulse(0);
        wr(32'h0B, 1, 1, "R8");
        wr(32'h000102, 3, 1, "R8");
        wr(32'h0, 1, 0, "R8");
        begin
            int stalled = 0;
            int leaks = 0;
            @(negedge clk);
            wr_valid = 1;
            wr_data = 32'h1;
            wr_size = 3'd1;
            #1;
            while (!wr_ready && stalled < 100) begin
                if (wr_pass) leaks++;
                stalled++;
                @(negedge clk);
                #1;
            end
            chk(stalled == 8, "R8", stalled, 8);
            chk(leaks == 0, "R8", leaks, 0);
            chk(wr_pass == 1, "R8", int'(wr_pass), 1);
            @(posedge clk);
            #1;
            wr_valid = 0;
        end

        // R10 release cancels a running burst
        cs_pulse(0);
        wr(32'hEC, 1, 1, "R10");
        wr(32'h000102, 3, 1, "R10");
        wr(32'h0, 1, 0, "R10");
        @(negedge clk);
        @(negedge clk);
        chk(dummy_valid == 1, "R10", int'(dummy_valid), 1);
        cs_pulse(1);
        @(negedge clk);
        chk(dummy_valid == 0 && wr_ready == 1, "R10", int'(dummy_valid), 0);
        wr(32'h0, 1, 1, "R10");
        drain(0, 8'h0, "R10");
        // R10 release before the address phase ends snooping
        cs_pulse(0);
        wr(32'h0B, 1, 1, "R10");
        wr(32'h000102, 3, 1, "R10");
        cs_pulse(1);
        wr(32'h0, 1, 1, "R10");
        drain(0, 8'h0, "R10");

        // R11 write in the chip-select cycle is not the opcode
        @(negedge clk);
        cs_assert = 1;
        wr_valid = 1;
        wr_data = 32'hEB;
        wr_size = 3'd1;
        #1;
        chk(wr_pass == 1, "R11", int'(wr_pass), 1);
        @(posedge clk);
        #1;
        cs_assert = 0;
        wr_valid = 0;
        wr(32'h03, 1, 1, "R11");
        wr(32'h000102, 3, 1, "R11");
        wr(32'h0, 1, 1, "R11");
        drain(0, 8'h0, "R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule